// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block keeps the coherence state and address tag of every line of a direct-mapped private cache. It sits on a plain shared bus that has no signal telling a requester whether other caches also hold a line. Each line is in one of four states: Invalid, Valid, Reserved or Dirty. Valid means the line may be shared with other caches. Reserved means the line is clean and held only here. Dirty means the line is held only here and memory is stale.

The write policy is hybrid. The first processor write to a Valid line is written through to memory and broadcast on the bus. That broadcast removes every other copy, so the line becomes Reserved. Any later write stays local, and the line becomes Dirty. A Dirty line is copied back to memory only when another address evicts it from its set, or when another cache reads it.

The controller takes one processor request or one snooped bus transaction per cycle. Snoops have priority. All results appear on registered outputs one cycle after the input is accepted. The data array is outside the block: the controller only reports when the cache must supply data and which memory writes to perform.

Top module: `wo_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and all registered outputs are low, so the first access to any address misses.
- R2: A processor read miss issues a bus read (command code 1) at the request address and installs the line Valid (state code 1); the response reports a miss.
- R3: A processor read hit reports a hit with the current state and causes no bus command, no memory write and no state change.
- R4: A processor write hit on a Valid line issues a write-through bus command (code 3) and a memory write with cause code 1 at the request address, and the line becomes Reserved (state code 2).
- R5: A processor write hit on a Reserved line moves it to Dirty (state code 3), and a write hit on a Dirty line leaves it Dirty; neither produces bus or memory traffic.
- R6: A processor write miss issues a read-with-intent-to-modify bus command (code 2) and installs the line Dirty.
- R7: On a miss whose victim line is Dirty, a copy-back memory write (cause code 2) is issued at the victim's address {old tag, set}; a clean or Invalid victim produces no memory write.
- R8: A snooped bus read (command 1) hitting a Dirty line asserts data supply, issues a memory write with cause code 3 at the snooped address, and leaves the line Valid.
- R9: A snooped bus read hitting a Reserved line moves it to Valid; on a Valid line it changes nothing; in neither case is data supplied.
- R10: A snooped read-with-intent-to-modify (2) or write-through (3) that hits a line makes it Invalid; data is supplied only for command 2 on a Dirty line.
- R11: While a snoop is presented, the processor ready output is low and the processor request is not taken; it is taken in the next cycle without a snoop.
- R12: Every response, bus command and memory write is registered and appears exactly one cycle after its request or snoop is accepted; an address index is the low SET_W bits of the line address and the tag is the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_resp_valid | output | 1 | Response to the request taken last cycle |
| cpu_resp_hit | output | 1 | That request hit |
| cpu_resp_state | output | 2 | Line state after that request |
| bus_out_valid | output | 1 | Bus command issued |
| bus_out_cmd | output | 2 | Bus command code (1 read, 2 read-for-ownership, 3 write-through) |
| bus_out_addr | output | ADDR_W | Bus command address |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_cmd | input | 2 | Snooped command code (same coding as bus_out_cmd) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_hit | output | 1 | Last snoop matched a held line |
| snp_supply | output | 1 | This cache must drive the snooped line's data |
| mem_wr_valid | output | 1 | Memory write requested |
| mem_wr_addr | output | ADDR_W | Memory write line address |
| mem_wr_cause | output | 2 | 1 write-through, 2 copy-back, 3 snoop flush |

## Verification
A wrong stored state can stay hidden until its line is touched again. It then shows as a wrong response state or hit flag, or as a bus command where none belongs. It can also show as a missing write-through, a missing copy-back, or a flush with no matching supply. The bench keeps its own table of tags and states and compares every output on every cycle. A corrupted line is therefore reported one cycle after the first access that depends on it. Directed sequences drive each state through each transition, and a long random phase over a few sets and tags mixes snoops with processor traffic.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_VAL = 2'd1,
    LN_RSV = 2'd2,
    LN_DRT = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_RWITM = 2'd2,
    BC_WTHRU = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    MW_NONE     = 2'd0,
    MW_THRU     = 2'd1,
    MW_COPYBACK = 2'd2,
    MW_FLUSH    = 2'd3
  } mem_cause_e;

  typedef struct packed {
    line_st_e   nxt;
    logic       wr_state;
    logic       wr_tag;
    bus_cmd_e   bus;
    mem_cause_e mem;
    logic       mem_victim;
    logic       supply;
    logic       hit;
  } act_t;
endpackage

// File: rtl/wo_tag_store.sv
module wo_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output wo_pkg::line_st_e rd_state,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_state_en,
  input  logic             wr_tag_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  wo_pkg::line_st_e wr_state,
  input  logic [TAG_W-1:0] wr_tag
);
  import wo_pkg::*;

  line_st_e   st_q  [SETS];
  logic [TAG_W-1:0] tag_mem [SETS];

  // state bits carry reset; tags are a plain memory with no reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LN_INV;
    end else if (wr_state_en) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_state = st_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/wo_proto.sv
module wo_proto (
  input  logic             do_snoop,
  input  logic             do_cpu,
  input  wo_pkg::bus_cmd_e snp_cmd,
  input  logic             cpu_write,
  input  wo_pkg::line_st_e cur,
  input  logic             tag_eq,
  output wo_pkg::act_t     act
);
  import wo_pkg::*;

  logic hit;
  assign hit = (cur != LN_INV) && tag_eq;

  always_comb begin
    act     = '0;
    act.nxt = cur;
    act.hit = hit;
    if (do_snoop) begin
      if (hit) begin
        unique case (snp_cmd)
          BC_READ: begin
            if (cur == LN_DRT) begin
              act.supply = 1'b1;
              act.mem    = MW_FLUSH;
            end
            if (cur != LN_VAL) begin
              act.nxt      = LN_VAL;
              act.wr_state = 1'b1;
            end
          end
          BC_RWITM: begin
            act.supply   = (cur == LN_DRT);
            act.nxt      = LN_INV;
            act.wr_state = 1'b1;
          end
          BC_WTHRU: begin
            act.nxt      = LN_INV;
            act.wr_state = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (do_cpu) begin
      if (hit) begin
        if (cpu_write) begin
          unique case (cur)
            LN_VAL: begin
              act.nxt      = LN_RSV;
              act.wr_state = 1'b1;
              act.bus      = BC_WTHRU;
              act.mem      = MW_THRU;
            end
            LN_RSV: begin
              act.nxt      = LN_DRT;
              act.wr_state = 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        act.wr_state = 1'b1;
        act.wr_tag   = 1'b1;
        act.bus      = cpu_write ? BC_RWITM : BC_READ;
        act.nxt      = cpu_write ? LN_DRT : LN_VAL;
        if (cur == LN_DRT) begin
          act.mem        = MW_COPYBACK;
          act.mem_victim = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wo_snoop_ctrl.sv
module wo_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_resp_valid,
  output logic              cpu_resp_hit,
  output logic [1:0]        cpu_resp_state,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_cmd,
  output logic [ADDR_W-1:0] bus_out_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [1:0]        mem_wr_cause
);
  import wo_pkg::*;

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;

  logic              cpu_take;
  logic [ADDR_W-1:0] sel_addr;
  logic [SET_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  line_st_e          cur_state;
  logic [TAG_W-1:0]  cur_tag;
  act_t              act;

  assign cpu_ready = !snp_valid;
  assign cpu_take  = cpu_req_valid && !snp_valid;
  assign sel_addr  = snp_valid ? snp_addr : cpu_req_addr;
  assign sel_idx   = sel_addr[SET_W-1:0];
  assign sel_tag   = sel_addr[ADDR_W-1:SET_W];

  wo_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (sel_idx),
    .rd_state    (cur_state),
    .rd_tag      (cur_tag),
    .wr_state_en (act.wr_state),
    .wr_tag_en   (act.wr_tag),
    .wr_idx      (sel_idx),
    .wr_state    (act.nxt),
    .wr_tag      (sel_tag)
  );

  wo_proto u_proto (
    .do_snoop  (snp_valid),
    .do_cpu    (cpu_take),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .cpu_write (cpu_req_write),
    .cur       (cur_state),
    .tag_eq    (cur_tag == sel_tag),
    .act       (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      cpu_resp_state <= '0;
      bus_out_valid  <= 1'b0;
      bus_out_cmd    <= '0;
      bus_out_addr   <= '0;
      snp_hit        <= 1'b0;
      snp_supply     <= 1'b0;
      mem_wr_valid   <= 1'b0;
      mem_wr_addr    <= '0;
      mem_wr_cause   <= '0;
    end else begin
      cpu_resp_valid <= cpu_take;
      cpu_resp_hit   <= cpu_take && act.hit;
      cpu_resp_state <= cpu_take ? act.nxt : 2'd0;
      bus_out_valid  <= act.bus != BC_NONE;
      bus_out_cmd    <= act.bus;
      bus_out_addr   <= (act.bus != BC_NONE) ? cpu_req_addr : '0;
      snp_hit        <= snp_valid && act.hit;
      snp_supply     <= act.supply;
      mem_wr_valid   <= act.mem != MW_NONE;
      mem_wr_cause   <= act.mem;
      if (act.mem == MW_NONE)
        mem_wr_addr <= '0;
      else if (act.mem_victim)
        mem_wr_addr <= {cur_tag, sel_idx};
      else
        mem_wr_addr <= sel_addr;
    end
  end
endmodule

// File: rtl/wo_snoop_ctrl_chk.sv
module wo_snoop_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_ready,
  input logic              cpu_resp_valid,
  input logic              cpu_resp_hit,
  input logic [1:0]        cpu_resp_state,
  input logic              bus_out_valid,
  input logic [1:0]        bus_out_cmd,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_supply,
  input logic              mem_wr_valid,
  input logic [1:0]        mem_wr_cause
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_resp_valid && !bus_out_valid && !mem_wr_valid && !snp_supply)); // R1
  AST_WTHRU_TO_RSV: assert property (@(posedge clk) disable iff (rst)
    (bus_out_valid && bus_out_cmd == 2'd3) |-> (cpu_resp_hit && cpu_resp_state == 2'd2)); // R4
  AST_RWITM_TO_DRT: assert property (@(posedge clk) disable iff (rst)
    (bus_out_valid && bus_out_cmd == 2'd2) |-> (!cpu_resp_hit && cpu_resp_state == 2'd3)); // R6
  AST_FLUSH_HAS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && mem_wr_cause == 2'd3) |-> snp_supply); // R8
  AST_SUPPLY_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> ($past(snp_valid) && $past(snp_cmd) != 2'd3)); // R10
  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !cpu_ready); // R11
  AST_BUS_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_out_valid |-> ($past(cpu_req_valid) && $past(cpu_ready))); // R12
endmodule

bind wo_snoop_ctrl wo_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_ready      (cpu_ready),
  .cpu_resp_valid (cpu_resp_valid),
  .cpu_resp_hit   (cpu_resp_hit),
  .cpu_resp_state (cpu_resp_state),
  .bus_out_valid  (bus_out_valid),
  .bus_out_cmd    (bus_out_cmd),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_supply     (snp_supply),
  .mem_wr_valid   (mem_wr_valid),
  .mem_wr_cause   (mem_wr_cause)
);

// File: tb/wo_snoop_ctrl_tb_top.sv
module wo_snoop_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int SET_W  = 4;
  localparam int NSETS  = 1 << SET_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic cpu_ready, cpu_resp_valid, cpu_resp_hit, bus_out_valid;
  logic snp_hit, snp_supply, mem_wr_valid;
  logic [1:0] cpu_resp_state, bus_out_cmd, mem_wr_cause;
  logic [ADDR_W-1:0] bus_out_addr, mem_wr_addr;

  always #(CLK_P/2) clk = ~clk;

  wo_snoop_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .cpu_resp_state(cpu_resp_state), .bus_out_valid(bus_out_valid), .bus_out_cmd(bus_out_cmd),
    .bus_out_addr(bus_out_addr), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_supply(snp_supply), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_cause(mem_wr_cause)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // reference table
  int mst [NSETS];
  int mtag[NSETS];
  // expected outputs for the next compare
  int e_rv, e_rh, e_rs, e_bv, e_bc, e_ba, e_sh, e_ss, e_mv, e_ma, e_mc;
  string prev_rq = "R1";

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic compare(input string rq);
    chk(cpu_resp_valid == e_rv, rq, "resp_valid", cpu_resp_valid, e_rv);
    chk(cpu_resp_hit == e_rh, rq, "resp_hit", cpu_resp_hit, e_rh);
    chk(cpu_resp_state == e_rs, rq, "resp_state", cpu_resp_state, e_rs);
    chk(bus_out_valid == e_bv, rq, "bus_valid", bus_out_valid, e_bv);
    if (e_bv != 0) begin
      chk(bus_out_cmd == e_bc, rq, "bus_cmd", bus_out_cmd, e_bc);
      chk(bus_out_addr == e_ba, rq, "bus_addr", bus_out_addr, e_ba);
    end
    chk(snp_hit == e_sh, rq, "snp_hit", snp_hit, e_sh);
    chk(snp_supply == e_ss, rq, "snp_supply", snp_supply, e_ss);
    chk(mem_wr_valid == e_mv, rq, "mem_valid", mem_wr_valid, e_mv);
    if (e_mv != 0) begin
      chk(mem_wr_addr == e_ma, rq, "mem_addr", mem_wr_addr, e_ma);
      chk(mem_wr_cause == e_mc, rq, "mem_cause", mem_wr_cause, e_mc);
    end
  endtask

  // predicts outputs of the next cycle and updates the table
  task automatic model(input bit sv, input int sc, input int sa, input bit cv, input bit cw, input int ca);
    int idx, tg, st;
    bit h;
    {e_rv, e_rh, e_rs, e_bv, e_bc, e_ba, e_sh, e_ss, e_mv, e_ma, e_mc} = '0;
    if (sv) begin
      idx = sa % NSETS; tg = sa / NSETS; st = mst[idx];
      h = (st != 0) && (mtag[idx] == tg);
      e_sh = h;
      if (h) begin
        if (sc == 1) begin
          if (st == 3) begin e_ss = 1; e_mv = 1; e_ma = sa; e_mc = 3; end
          mst[idx] = 1;
        end else if (sc == 2) begin
          e_ss = (st == 3);
          mst[idx] = 0;
        end else if (sc == 3) begin
          mst[idx] = 0;
        end
      end
    end else if (cv) begin
      idx = ca % NSETS; tg = ca / NSETS; st = mst[idx];
      h = (st != 0) && (mtag[idx] == tg);
      e_rv = 1; e_rh = h;
      if (h) begin
        if (cw && st == 1) begin
          mst[idx] = 2; e_bv = 1; e_bc = 3; e_ba = ca; e_mv = 1; e_ma = ca; e_mc = 1;
        end else if (cw && st == 2) begin
          mst[idx] = 3;
        end
      end else begin
        if (st == 3) begin e_mv = 1; e_mc = 2; e_ma = mtag[idx] * NSETS + idx; end
        e_bv = 1; e_bc = cw ? 2 : 1; e_ba = ca;
        mst[idx] = cw ? 3 : 1; mtag[idx] = tg;
      end
      e_rs = mst[idx];
    end
  endtask

  // called just after a falling edge
  task automatic step(input bit sv, input int sc, input int sa, input bit cv, input bit cw,
                      input int ca, input string rq);
    compare(prev_rq);
    snp_valid = sv; snp_cmd = 2'(sc); snp_addr = ADDR_W'(sa);
    cpu_req_valid = cv; cpu_req_write = cw; cpu_req_addr = ADDR_W'(ca);
    #1;
    chk(cpu_ready == !sv, "R11", "cpu_ready", cpu_ready, !sv);
    model(sv, sc, sa, cv, cw, ca);
    prev_rq = rq;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string rq); step(0, 0, 0, 1, 0, a, rq); endtask
  task automatic wr(input int a, input string rq); step(0, 0, 0, 1, 1, a, rq); endtask
  task automatic sn(input int c, input int a, input string rq); step(1, c, a, 0, 0, 0, rq); endtask

  initial begin
    for (int i = 0; i < NSETS; i++) begin mst[i] = 0; mtag[i] = 0; end
    {e_rv, e_rh, e_rs, e_bv, e_bc, e_ba, e_sh, e_ss, e_mv, e_ma, e_mc} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset, first accesses miss
    rd(16'h0013, "R2");
    rd(16'h0013, "R3");
    wr(16'h0013, "R4");
    wr(16'h0013, "R5");
    wr(16'h0013, "R5");
    sn(1, 16'h0013, "R8");
    rd(16'h0013, "R8");
    wr(16'h0025, "R6");
    wr(16'h0135, "R7");
    rd(16'h0047, "R2");
    rd(16'h0147, "R7");
    wr(16'h0147, "R4");
    sn(1, 16'h0147, "R9");
    sn(1, 16'h0147, "R9");
    rd(16'h0147, "R9");
    sn(2, 16'h0135, "R10");
    rd(16'h0135, "R10");
    sn(3, 16'h0013, "R10");
    sn(3, 16'h0113, "R10");
    rd(16'h0013, "R10");
    // snoop and processor request together
    step(1, 1, 16'h0058, 1, 1, 16'h0013, "R11");
    wr(16'h0013, "R11");
    sn(2, 16'h0013, "R10");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      automatic int a = ($urandom % 4) * NSETS + ($urandom % 4);
      automatic int r = $urandom % 8;
      if (r < 2) step(1, 1 + ($urandom % 3), a, $urandom % 2, $urandom % 2, a, "R12");
      else if (r < 7) step(0, 0, 0, 1, $urandom % 2, a, "R12");
      else step(0, 0, 0, 0, 0, 0, "R12");
    end
    step(0, 0, 0, 0, 0, 0, "R12");
    compare(prev_rq);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule